// File: doc/BRIEF.md
# HDLC Frame Receiver with Two-Byte Address Filter

This block turns a bit-serial HDLC line into a byte stream. Each input bit is taken only in a cycle where the bit-enable strobe is high. The block finds flags, removes the zeros that the sender inserted after runs of five ones, and checks each frame against its 16-bit frame check sequence. It decides from the first two bytes of the frame whether the frame is kept. Each of those two bytes is compared with a programmed value under a per-bit mask, and the all-ones value is always accepted as a broadcast.

Accepted bytes leave one per cycle on a valid strobe, with a start marker on the first byte. The two check-sequence bytes are never delivered. Every frame that reaches the block ends with a single end-of-frame event, on a cycle with no data. That event carries four status bits: check-sequence error, abort, rejected by address and overflow. A frame is only delivered after its address has been judged, so the output lags the line by three bytes.

The control is a five-state machine:
- `ST_HUNT` waits for a flag.
- `ST_FRAME` collects bytes.
- `ST_FLUSH` sends the last byte that is not part of the check sequence.
- `ST_DONE` sends the end event of a properly closed frame.
- `ST_FAIL` sends the end event of an aborted or overlong frame.

The transitions are:
- `ST_HUNT` to `ST_FRAME` on a flag.
- `ST_FRAME` to `ST_FLUSH` on a flag that closes four or more bytes.
- `ST_FRAME` back to `ST_FRAME` on a flag that closes fewer than four bytes.
- `ST_FRAME` to `ST_FAIL` on an abort inside a frame that holds at least one byte, or on the byte after the limit.
- `ST_FRAME` to `ST_HUNT` on an abort in a frame that holds no byte.
- `ST_FLUSH` to `ST_DONE`, then `ST_DONE` to `ST_FRAME`.
- `ST_FAIL` to `ST_HUNT`.

Top module: `hdlc_rx_filter`

## Requirements
- R1: After reset, `out_valid`, `out_sof`, `out_eof` and all status outputs are 0, and `out_data` is 0.
- R2: The pattern 01111110 (first bit on the line first) opens and closes a frame. Bytes are assembled least significant bit first. A closed frame of N >= 4 bytes delivers its bytes 0 to N-3 in order, with `out_sof` high on byte 0. It then raises `out_eof` for one cycle with `out_valid` low. The last two bytes, the check sequence, are not delivered.
- R3: A 0 received after exactly five consecutive 1s inside a frame is removed and does not count as a data bit.
- R4: Two flags that share one 0 (011111101111110) are both recognised. The second flag opens the next frame.
- R5: Seven or more 1s received when no byte has yet been gathered produce no output. Idle all-ones between frames therefore has no effect.
- R6: The check sequence is CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF. It is sent inverted, low byte first. A frame whose running residue at the closing flag is not 0xF0B8 ends with `out_crc_err`=1 in its end event. Its bytes are still delivered.
- R7: With `filt_en`=1, byte 0 matches when every bit set in `addr0_mask` equals the same bit of `addr0_val`. Byte 1 is checked the same way against `addr1_val` and `addr1_mask`. Bits whose mask bit is 0 are not compared.
- R8: With `filt_en`=1, an address byte equal to 0xFF matches whatever value and mask are programmed for it.
- R9: With `filt_en`=1, a frame whose byte 0 or byte 1 fails to match delivers no data byte. Its end event has `out_addr_rej`=1.
- R10: With `filt_en`=0, every closed frame of four or more bytes is delivered whatever its address bytes.
- R11: A seventh consecutive 1 inside a frame that holds K >= 1 complete bytes ends the frame with one end event with `out_abort`=1. Only bytes 0 to K-4 have been delivered before that event. Input is then ignored until the next flag.
- R12: A frame closed with fewer than four bytes produces no output at all.
- R13: When byte number MAX_BYTES+1 of a frame completes, an end event with `out_overflow`=1 follows. Only bytes 0 to MAX_BYTES-4 have been delivered. The rest of the frame is ignored until a flag.
- R14: Input bits are taken only in cycles where `bit_en`=1. Any number of idle cycles between bits leaves the result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit is present this cycle |
| bit_in | input | 1 | Serial line bit |
| filt_en | input | 1 | 1 = address filtering on |
| addr0_val | input | 8 | Expected value of address byte 0 |
| addr0_mask | input | 8 | Compare mask of address byte 0 (1 = compared) |
| addr1_val | input | 8 | Expected value of address byte 1 |
| addr1_mask | input | 8 | Compare mask of address byte 1 (1 = compared) |
| out_valid | output | 1 | `out_data` holds a delivered byte |
| out_sof | output | 1 | Delivered byte is byte 0 of its frame |
| out_data | output | 8 | Delivered byte |
| out_eof | output | 1 | End-of-frame event; the status bits are valid |
| out_crc_err | output | 1 | Check-sequence mismatch |
| out_abort | output | 1 | Frame ended by seven ones |
| out_addr_rej | output | 1 | Frame rejected by the address filter |
| out_overflow | output | 1 | Frame exceeded MAX_BYTES |

## Verification
The bench aims at the bit-level edges of framing: runs of ones that need stuffing, flags that share a zero, idle ones right after a closing flag, and bits spread out by idle strobes. A design that mishandled any of these would deliver corrupted bytes, miss or invent a frame, or report a false abort. On the filter side, the bench covers masked-off address bits, a broadcast byte in either position, and a mismatch in either byte. A wrong filter would leak a rejected frame's data or swallow an accepted one. The bench also checks the ends of the length range: frames of two, three and four bytes, an abort after a few bytes, and a frame longer than the limit. An off-by-one in the three-byte holdback would show up there as a missing or extra byte before the end event.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_FRAME,
        ST_FLUSH,
        ST_DONE,
        ST_FAIL
    } rx_state_t;

    localparam logic [15:0] CRC_SEED     = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE  = 16'hF0B8;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;

    localparam logic [2:0]  RUN_STUFF    = 3'd5;
    localparam logic [2:0]  RUN_FLAG     = 3'd6;
    localparam logic [2:0]  RUN_SAT      = 3'd7;

endpackage

// File: rtl/hdlc_rx_bitproc.sv
module hdlc_rx_bitproc
    import hdlc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    output logic       flag_p,
    output logic       abort_p,
    output logic       byte_p,
    output logic       flag_aligned,
    output logic [7:0] byte_q
);

    logic [2:0] ones;
    logic [2:0] bcnt;
    logic [7:0] sh;
    logic       take;

    // a data bit is any bit that is neither a stuffed zero, a flag end nor part of an abort run
    always_comb begin
        if (bit_in) take = bit_en && (ones < RUN_FLAG);
        else        take = bit_en && (ones != RUN_STUFF) && (ones != RUN_FLAG);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones         <= '0;
            bcnt         <= '0;
            sh           <= '0;
            flag_p       <= 1'b0;
            abort_p      <= 1'b0;
            byte_p       <= 1'b0;
            flag_aligned <= 1'b0;
            byte_q       <= '0;
        end else begin
            flag_p  <= 1'b0;
            abort_p <= 1'b0;
            byte_p  <= 1'b0;
            if (bit_en) begin
                if (bit_in) begin
                    if (ones != RUN_SAT) ones <= ones + 3'd1;
                    if (ones == RUN_FLAG) abort_p <= 1'b1;
                end else begin
                    ones <= '0;
                    if (ones == RUN_FLAG) begin
                        flag_p       <= 1'b1;
                        flag_aligned <= (bcnt == 3'd7);
                    end
                end
                if (take) begin
                    sh   <= {bit_in, sh[7:1]};
                    bcnt <= bcnt + 3'd1;
                    if (bcnt == 3'd7) begin
                        byte_p <= 1'b1;
                        byte_q <= {bit_in, sh[7:1]};
                    end
                end else if (!bit_in && ones == RUN_FLAG) begin
                    bcnt <= '0;
                end
            end
        end
    end

    AST_BYTE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_p |-> $past(bit_en)); // R14
    AST_FLAG_ENDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flag_p |-> $past(bit_en && !bit_in)); // R4
    AST_ABORT_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_p |-> $past(bit_en && bit_in)); // R11
    AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({flag_p, abort_p, byte_p}) <= 1); // R3

endmodule

// File: rtl/hdlc_rx_crc16.sv
module hdlc_rx_crc16
    import hdlc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       upd,
    input  logic [7:0] din,
    output logic       crc_ok
);

    logic [15:0] crc;

    function automatic logic [15:0] crc_byte(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REV;
            else             c = c >> 1;
        end
        return c;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n)    crc <= CRC_SEED;
        else if (init) crc <= CRC_SEED;
        else if (upd)  crc <= crc_byte(crc, din);
    end

    assign crc_ok = (crc == CRC_RESIDUE);

    AST_SEED_NOT_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> !crc_ok); // R6

endmodule

// File: rtl/hdlc_rx_addr_cmp.sv
module hdlc_rx_addr_cmp (
    input  logic [7:0] byte_in,
    input  logic [7:0] val,
    input  logic [7:0] mask,
    output logic       hit
);

    assign hit = (((byte_in ^ val) & mask) == 8'h00) || (byte_in == 8'hFF);

endmodule

// File: rtl/hdlc_rx_filter.sv
module hdlc_rx_filter
    import hdlc_rx_pkg::*;
#(
    parameter int MAX_BYTES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       filt_en,
    input  logic [7:0] addr0_val,
    input  logic [7:0] addr0_mask,
    input  logic [7:0] addr1_val,
    input  logic [7:0] addr1_mask,
    output logic       out_valid,
    output logic       out_sof,
    output logic [7:0] out_data,
    output logic       out_eof,
    output logic       out_crc_err,
    output logic       out_abort,
    output logic       out_addr_rej,
    output logic       out_overflow
);

    localparam int ADDR_BYTES = 2;
    localparam int FCS_BYTES  = 2;
    localparam int PIPE_D     = ADDR_BYTES + 1;
    localparam int MIN_BYTES  = ADDR_BYTES + FCS_BYTES;
    localparam int CNT_W      = $clog2(MAX_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_BYTES);
    localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_PIPE = CNT_W'(PIPE_D);
    localparam logic [CNT_W-1:0] CNT_MIN  = CNT_W'(MIN_BYTES);

    rx_state_t        state, state_nx;
    logic             flag_p, abort_p, byte_p, flag_aligned;
    logic [7:0]       byte_q;
    logic             crc_ok;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       pipe [PIPE_D];
    logic [7:0]       cmp_val  [ADDR_BYTES];
    logic [7:0]       cmp_mask [ADDR_BYTES];
    logic [ADDR_BYTES-1:0] hit;
    logic             acc;
    logic             fin_crc;
    logic             fail_abort, fail_ovf;

    hdlc_rx_bitproc u_bits (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .flag_p(flag_p), .abort_p(abort_p), .byte_p(byte_p),
        .flag_aligned(flag_aligned), .byte_q(byte_q)
    );

    hdlc_rx_crc16 u_crc (
        .clk(clk), .rst_n(rst_n), .init(flag_p),
        .upd(byte_p && state == ST_FRAME), .din(byte_q), .crc_ok(crc_ok)
    );

    assign cmp_val[0]  = addr0_val;
    assign cmp_val[1]  = addr1_val;
    assign cmp_mask[0] = addr0_mask;
    assign cmp_mask[1] = addr1_mask;

    // before the shift that brings in byte 2, the address bytes sit in the upper pipe slots
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
        hdlc_rx_addr_cmp u_cmp (
            .byte_in(pipe[g + 1]), .val(cmp_val[g]), .mask(cmp_mask[g]), .hit(hit[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:  if (flag_p) state_nx = ST_FRAME;
            ST_FRAME: begin
                if (flag_p)                       state_nx = (cnt >= CNT_MIN) ? ST_FLUSH : ST_FRAME;
                else if (abort_p)                 state_nx = (cnt != '0) ? ST_FAIL : ST_HUNT;
                else if (byte_p && cnt == CNT_MAX) state_nx = ST_FAIL;
            end
            ST_FLUSH: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_FRAME;
            ST_FAIL:  state_nx = ST_HUNT;
            default:  state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_sof      <= 1'b0;
            out_data     <= '0;
            out_eof      <= 1'b0;
            out_crc_err  <= 1'b0;
            out_abort    <= 1'b0;
            out_addr_rej <= 1'b0;
            out_overflow <= 1'b0;
            cnt          <= '0;
            acc          <= 1'b0;
            fin_crc      <= 1'b0;
            fail_abort   <= 1'b0;
            fail_ovf     <= 1'b0;
            for (int i = 0; i < PIPE_D; i++) pipe[i] <= '0;
        end else begin
            out_valid    <= 1'b0;
            out_sof      <= 1'b0;
            out_eof      <= 1'b0;
            out_crc_err  <= 1'b0;
            out_abort    <= 1'b0;
            out_addr_rej <= 1'b0;
            out_overflow <= 1'b0;
            unique case (state)
                ST_HUNT: if (flag_p) cnt <= '0;
                ST_FRAME: begin
                    if (flag_p) begin
                        fin_crc <= !crc_ok || !flag_aligned;
                        cnt     <= '0;
                    end else if (abort_p) begin
                        fail_abort <= 1'b1;
                        fail_ovf   <= 1'b0;
                    end else if (byte_p) begin
                        if (cnt == CNT_MAX) begin
                            fail_abort <= 1'b0;
                            fail_ovf   <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                            for (int i = 0; i < PIPE_D - 1; i++) pipe[i] <= pipe[i + 1];
                            pipe[PIPE_D - 1] <= byte_q;
                            if (cnt == CNT_ADDR) acc <= !filt_en || (&hit);
                            if (cnt >= CNT_PIPE && acc) begin
                                out_valid <= 1'b1;
                                out_data  <= pipe[0];
                                out_sof   <= (cnt == CNT_PIPE);
                            end
                        end
                    end
                end
                ST_FLUSH: begin
                    if (acc) begin
                        out_valid <= 1'b1;
                        out_data  <= pipe[0];
                    end
                end
                ST_DONE: begin
                    out_eof      <= 1'b1;
                    out_crc_err  <= fin_crc;
                    out_addr_rej <= !acc;
                end
                ST_FAIL: begin
                    out_eof      <= 1'b1;
                    out_abort    <= fail_abort;
                    out_overflow <= fail_ovf;
                end
                default: ;
            endcase
        end
    end

    AST_DATA_EOF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_eof)); // R2
    AST_SOF_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |=> !out_sof); // R2
    AST_EOF_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |=> !out_valid); // R2
    AST_REJ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof && out_addr_rej) |-> !$past(out_valid)); // R9
    AST_ONE_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> ($countones({out_abort, out_overflow, out_crc_err}) <= 1)); // R11

endmodule

// File: tb/hdlc_rx_filter_bench.sv
`timescale 1ns/1ps
module hdlc_rx_filter_bench;

    localparam int MAXB = 32;
    localparam int EOF_TAG = 4096;

    logic clk = 1'b0;
    logic rst_n, bit_en, bit_in, filt_en;
    logic [7:0] a0v, a0m, a1v, a1m;
    logic out_valid, out_sof, out_eof, out_crc_err, out_abort, out_addr_rej, out_overflow;
    logic [7:0] out_data;

    int checks = 0;
    int fails = 0;
    int gap = 0;
    int tx_ones = 0;
    string cur_req = "R1";
    int exp_q[$];
    logic [7:0] frm[$];

    always #10 clk = ~clk;

    hdlc_rx_filter #(.MAX_BYTES(MAXB)) u_hdlc_rx_filter (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .filt_en(filt_en),
        .addr0_val(a0v), .addr0_mask(a0m), .addr1_val(a1v), .addr1_mask(a1m),
        .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data), .out_eof(out_eof),
        .out_crc_err(out_crc_err), .out_abort(out_abort), .out_addr_rej(out_addr_rej),
        .out_overflow(out_overflow)
    );

    // per-cycle comparison of every output event against the model's queue
    always @(negedge clk) begin
        if (rst_n && (out_valid || out_eof)) begin
            int obs;
            obs = out_eof ? (EOF_TAG + (out_crc_err ? 8 : 0) + (out_abort ? 4 : 0)
                             + (out_addr_rej ? 2 : 0) + (out_overflow ? 1 : 0))
                          : ((out_sof ? 256 : 0) + int'(out_data));
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected event actual=%0h expected=none", cur_req, obs);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != obs) begin
                    fails++;
                    $display("FAIL %s: actual=%0h expected=%0h", cur_req, obs, e);
                end
            end
        end
    end

    initial begin
        #(20ns * 150000);
        fails++;
        $display("FAIL %s: watchdog actual=running expected=finished", cur_req);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic send_bit(input logic b);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_raw(input logic [7:0] pat, input int n);
        for (int i = 0; i < n; i++) send_bit(pat[i]);
        tx_ones = 0;
    endtask

    task automatic send_flag();
        send_raw(8'h7E, 8);
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
        tx_ones = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            send_bit(v[i]);
            if (v[i]) begin
                tx_ones++;
                if (tx_ones == 5) begin
                    send_bit(1'b0);
                    tx_ones = 0;
                end
            end else begin
                tx_ones = 0;
            end
        end
    endtask

    function automatic logic [15:0] calc_fcs();
        logic [15:0] r;
        r = 16'hFFFF;
        foreach (frm[i]) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = r[0] ^ frm[i][b];
                r = r >> 1;
                if (fb) r = r ^ 16'h8408;
            end
        end
        return ~r;
    endfunction

    function automatic bit addr_ok(input logic [7:0] b, input logic [7:0] v, input logic [7:0] m);
        if (b == 8'hFF) return 1'b1;
        for (int i = 0; i < 8; i++) if (m[i] && (b[i] != v[i])) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit frame_acc();
        if (!filt_en) return 1'b1;
        return addr_ok(frm[0], a0v, a0m) && addr_ok(frm[1], a1v, a1m);
    endfunction

    task automatic push_eof(input bit crc, input bit ab, input bit rej, input bit ovf);
        exp_q.push_back(EOF_TAG + (crc ? 8 : 0) + (ab ? 4 : 0) + (rej ? 2 : 0) + (ovf ? 1 : 0));
    endtask

    task automatic push_data(input int upto);
        for (int j = 0; j <= upto; j++) exp_q.push_back((j == 0 ? 256 : 0) + int'(frm[j]));
    endtask

    // closed frame: payload from frm, then FCS, then closing flag
    task automatic frame_closed(input bit bad);
        logic [15:0] f;
        f = calc_fcs() ^ (bad ? 16'h0001 : 16'h0000);
        if (frm.size() + 2 >= 4) begin
            bit a;
            a = frame_acc();
            if (a) push_data(frm.size() - 1);
            push_eof(bad, 1'b0, !a, 1'b0);
        end
        foreach (frm[i]) send_byte(frm[i]);
        send_byte(f[7:0]);
        send_byte(f[15:8]);
        send_flag();
    endtask

    task automatic frame_aborted();
        int k;
        k = frm.size();
        if (k >= 1) begin
            if (k >= 4 && frame_acc()) push_data(k - 4);
            push_eof(1'b0, 1'b1, 1'b0, 1'b0);
        end
        foreach (frm[i]) send_byte(frm[i]);
        send_ones(8);
    endtask

    task automatic end_test();
        repeat (10) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: pending events actual=%0d expected=0", cur_req, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic set_frame3(input logic [7:0] x, input logic [7:0] y, input logic [7:0] z);
        frm.delete();
        frm.push_back(x); frm.push_back(y); frm.push_back(z);
    endtask

    initial begin
        rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; filt_en = 1'b0;
        a0v = 8'h00; a0m = 8'h00; a1v = 8'h00; a1m = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cur_req = "R1";
        checks++;
        if (out_valid || out_sof || out_eof || out_crc_err || out_abort || out_addr_rej
            || out_overflow || out_data != 8'h00) begin
            fails++;
            $display("FAIL R1: actual=%b%b%b%b%b%b%b/%0h expected=0", out_valid, out_sof, out_eof,
                     out_crc_err, out_abort, out_addr_rej, out_overflow, out_data);
        end

        // R2 basic frame after idle ones
        cur_req = "R2";
        send_ones(12);
        send_flag();
        frm.delete(); frm.push_back(8'h12); frm.push_back(8'h34); frm.push_back(8'hA5); frm.push_back(8'h00);
        frame_closed(1'b0);
        end_test();

        // R3 payload full of ones forces stuffing
        cur_req = "R3";
        frm.delete();
        frm.push_back(8'h03); frm.push_back(8'hFF); frm.push_back(8'h7E);
        frm.push_back(8'h3F); frm.push_back(8'hF8); frm.push_back(8'h1F);
        frame_closed(1'b0);
        end_test();

        // R4 closing flag shares its zero with the next flag
        cur_req = "R4";
        set_frame3(8'h21, 8'h43, 8'h65);
        frame_closed(1'b0);
        send_raw(8'h3F, 7);
        set_frame3(8'h55, 8'hAA, 8'h01);
        frame_closed(1'b0);
        end_test();

        // R5 idle ones after a closing flag, then a new frame
        cur_req = "R5";
        send_ones(16);
        end_test();
        send_flag();
        set_frame3(8'h01, 8'h02, 8'h03);
        frame_closed(1'b0);
        end_test();

        // R6 corrupted check sequence
        cur_req = "R6";
        set_frame3(8'h10, 8'h20, 8'h30);
        frame_closed(1'b1);
        end_test();

        // R7 masked address compare
        cur_req = "R7";
        filt_en = 1'b1; a0v = 8'hA0; a0m = 8'hF0; a1v = 8'h05; a1m = 8'hFF;
        set_frame3(8'hA7, 8'h05, 8'h99);
        frame_closed(1'b0);
        end_test();

        // R8 broadcast in either address byte
        cur_req = "R8";
        set_frame3(8'hFF, 8'h05, 8'h11);
        frame_closed(1'b0);
        set_frame3(8'hA3, 8'hFF, 8'h12);
        frame_closed(1'b0);
        end_test();

        // R9 mismatch in byte 0, then in byte 1
        cur_req = "R9";
        set_frame3(8'hB0, 8'h05, 8'h22);
        frame_closed(1'b0);
        set_frame3(8'hA0, 8'h06, 8'h22);
        frame_closed(1'b0);
        end_test();

        // R10 filter off delivers a non-matching frame
        cur_req = "R10";
        filt_en = 1'b0;
        set_frame3(8'hB0, 8'h06, 8'h33);
        frame_closed(1'b0);
        end_test();

        // R11 abort after six bytes, abort after two, then recovery
        cur_req = "R11";
        frm.delete();
        for (int i = 0; i < 6; i++) frm.push_back(8'(8'h30 + i));
        frame_aborted();
        send_ones(8);
        send_flag();
        frm.delete(); frm.push_back(8'h81); frm.push_back(8'h18);
        frame_aborted();
        send_flag();
        frm.delete(); frm.push_back(8'h77); frm.push_back(8'h66);
        frame_closed(1'b0);
        end_test();

        // R12 frames of three and two bytes are dropped
        cur_req = "R12";
        frm.delete(); frm.push_back(8'h42);
        frame_closed(1'b0);
        frm.delete();
        frame_closed(1'b0);
        end_test();

        // R13 frame longer than the limit
        cur_req = "R13";
        frm.delete();
        for (int i = 0; i < 40; i++) frm.push_back(8'(i * 7 + 1));
        push_data(MAXB - 4);
        push_eof(1'b0, 1'b0, 1'b0, 1'b1);
        begin
            logic [15:0] f;
            f = calc_fcs();
            foreach (frm[i]) send_byte(frm[i]);
            send_byte(f[7:0]);
            send_byte(f[15:8]);
            send_flag();
        end
        frm.delete(); frm.push_back(8'h01); frm.push_back(8'h02);
        frame_closed(1'b0);
        end_test();

        // R14 idle cycles between strobed bits
        cur_req = "R14";
        gap = 2;
        set_frame3(8'hC3, 8'h3C, 8'h5A);
        frame_closed(1'b0);
        gap = 0;
        end_test();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule